// File: doc/BRIEF.md
# Set-Associative Lookup Unit with Array-Activity Counters

This block holds the tag side of a set-associative cache and nothing else. It keeps a tag, a valid bit and a true-LRU age for every way of every set. It answers lookups with a hit flag and the matching way. It takes inserts that overwrite one way of one set. It stores no cache data. Instead, it counts how many tag-array reads and data-array reads each operation would cost, so that the energy of a cache organisation can be estimated.

A mode input chooses how data reads are charged. In parallel mode, every lookup reads the data of every way, and the response arrives one cycle after the request. In sequential mode, the tag compare comes first and only the hitting way's data is read afterwards, so the response arrives one cycle later. The geometry comes from three parameters: total capacity, block size and associativity. An address is split into tag (upper bits), set index (middle bits) and byte offset (lower bits).

Top module: `tag_lookup_unit`

## Requirements
- R1: The set count is CACHE_BYTES / (BLOCK_BYTES * WAYS). An address is split as {tag, index, offset}, most significant first, and the offset is log2(BLOCK_BYTES) bits wide. Addresses that differ only in the offset select the same block. A block size that is below 4 or is not a power of two stops elaboration.
- R2: A lookup hits when a valid way of the indexed set holds the same tag. `respHit` is 1 on a hit and `respWay` gives that way's index. On a miss, `respHit` is 0.
- R3: With `seqMode`=0, `respValid` pulses for one cycle, one clock edge after the cycle in which the lookup is presented. With `seqMode`=1, the pulse comes two edges after it.
- R4: Every accepted lookup adds WAYS to the tag-access count.
- R5: With `seqMode`=0, every accepted lookup adds WAYS to the data-access count, on a hit or a miss.
- R6: With `seqMode`=1, an accepted lookup adds 1 to the data-access count on a hit and 0 on a miss.
- R7: An insert adds 1 to each count and writes one way. That way is the lowest-numbered invalid way of the set if there is one, otherwise the least recently used way. The chosen way appears on `insertWay` one edge later.
- R8: A hit, or an insert, makes the touched way the most recently used way of its set. At reset, way 0 is the most recently used way and way WAYS-1 is the least recently used.
- R9: If `lookupValid` and `insertValid` are high in the same cycle, the insert is performed and the lookup is dropped. The dropped lookup produces no response, no count change and no LRU change.
- R10: Both counts stop at their all-ones value (2^CNT_W - 1) instead of wrapping.
- R11: `statClear` sets both counts to 0 on the next edge. It overrides any increment in that same cycle.
- R12: After reset, both counts are 0, `respValid` is 0 and every way is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seqMode | input | 1 | 1: sequential tag-then-data mode; 0: parallel mode |
| statClear | input | 1 | Synchronous clear of both counters |
| lookupValid | input | 1 | Lookup request strobe |
| lookupAddr | input | ADDR_W | Lookup byte address |
| insertValid | input | 1 | Insert request strobe |
| insertAddr | input | ADDR_W | Byte address of the block being inserted |
| respValid | output | 1 | Lookup response pulse |
| respHit | output | 1 | Lookup hit flag |
| respWay | output | WAY_W | Way index on a hit |
| insertWay | output | WAY_W | Way written by the most recent insert |
| tagAccessCount | output | CNT_W | Saturating tag-array read count |
| dataAccessCount | output | CNT_W | Saturating data-array read count |

## Verification
The assertions take three things for granted about the inputs. First, an insert never places a tag that is already present in its set, so at most one way matches. Second, `seqMode` does not change while a lookup is still in flight. Third, the counters are checked for exact steps only below saturation. The stimulus keeps to all three rules. Every inserted tag in a set is new. The mode is switched only after the pipeline has drained. The saturation phase runs after a clear, with counters narrowed through the CNT_W parameter. Expected hits, ways, victims and counts come from a small reference model of true-LRU ordering plus plain arithmetic on the counter increments.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic lookupFire;  // accepted lookup this cycle
    logic insertFire;  // insert this cycle
    logic dataAll;     // charge every way's data read
    logic dataOne;     // charge one data read
    logic clearStats;  // zero both counters
  } tlu_strobe_t;
endpackage

// File: rtl/tlu_datapath.sv
module tlu_datapath
  import tlu_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int SETS   = 4,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 10,
  parameter int WAY_W  = 2,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlu_strobe_t       strb,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] insertAddr,
  output logic              lookupHit,
  output logic [WAY_W-1:0]  lookupWay,
  output logic [WAY_W-1:0]  insertWay,
  output logic [CNT_W-1:0]  tagCount,
  output logic [CNT_W-1:0]  dataCount
);
  localparam logic [CNT_W:0]   WAYS_ADD = (CNT_W+1)'(WAYS);
  localparam logic [WAY_W-1:0] OLDEST   = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAY_W-1:0] ageMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];

  logic [IDX_W-1:0] lkIdx, insIdx, touchIdx;
  logic [TAG_W-1:0] lkTag, insTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] victimWay, touchWay;
  logic             touchEn;

  assign lkIdx  = lookupAddr[OFF_W +: IDX_W];
  assign lkTag  = lookupAddr[ADDR_W-1 -: TAG_W];
  assign insIdx = insertAddr[OFF_W +: IDX_W];
  assign insTag = insertAddr[ADDR_W-1 -: TAG_W];

  // Parallel tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validMem[lkIdx][w] && (tagMem[lkIdx][w] == lkTag);
  end

  always_comb begin
    lookupWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) lookupWay = WAY_W'(w);
  end
  assign lookupHit = |hitVec;

  // Victim: lowest invalid way first, otherwise the oldest way
  always_comb begin
    logic found;
    found     = 1'b0;
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !validMem[insIdx][w]) begin
        victimWay = WAY_W'(w);
        found     = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (ageMem[insIdx][w] == OLDEST) victimWay = WAY_W'(w);
  end

  always_comb begin
    touchEn  = strb.insertFire || (strb.lookupFire && lookupHit);
    touchIdx = strb.insertFire ? insIdx : lkIdx;
    touchWay = strb.insertFire ? victimWay : lookupWay;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagMem[s][w] <= '0;
          ageMem[s][w] <= WAY_W'(w);
        end
      end
      insertWay <= '0;
    end else begin
      if (touchEn)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == touchWay)
            ageMem[touchIdx][w] <= '0;
          else if (ageMem[touchIdx][w] < ageMem[touchIdx][touchWay])
            ageMem[touchIdx][w] <= ageMem[touchIdx][w] + 1'b1;
      if (strb.insertFire) begin
        validMem[insIdx][victimWay] <= 1'b1;
        tagMem[insIdx][victimWay]   <= insTag;
        insertWay                   <= victimWay;
      end
    end
  end

  // Saturating activity counters
  logic [CNT_W:0] tagAdd, dataAdd, tagSum, dataSum;
  always_comb begin
    tagAdd  = strb.lookupFire ? WAYS_ADD : (CNT_W+1)'(strb.insertFire);
    dataAdd = strb.dataAll ? WAYS_ADD : (CNT_W+1)'(strb.dataOne);
    tagSum  = {1'b0, tagCount} + tagAdd;
    dataSum = {1'b0, dataCount} + dataAdd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clearStats) begin
      tagCount  <= '0;
      dataCount <= '0;
    end else begin
      tagCount  <= tagSum[CNT_W]  ? '1 : tagSum[CNT_W-1:0];
      dataCount <= dataSum[CNT_W] ? '1 : dataSum[CNT_W-1:0];
    end
  end

  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));
  assert_mru_touch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    touchEn |=> ageMem[$past(touchIdx)][$past(touchWay)] == '0);
  assert_insert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.insertFire && !strb.clearStats && tagCount < {CNT_W{1'b1}})
      |=> tagCount == $past(tagCount) + 1'b1);  // also R9: no WAYS charge
  assert_seq_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lookupFire && !strb.dataAll && !strb.dataOne && !strb.clearStats)
      |=> $stable(dataCount));
  assert_no_decrease_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearStats |=> (tagCount >= $past(tagCount) && dataCount >= $past(dataCount)));
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearStats |=> (tagCount == '0 && dataCount == '0));
endmodule

// File: rtl/tlu_ctrl.sv
module tlu_ctrl
  import tlu_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seqMode,
  input  logic             statClear,
  input  logic             lookupValid,
  input  logic             insertValid,
  input  logic             lookupHit,
  input  logic [WAY_W-1:0] lookupWay,
  output tlu_strobe_t      strb,
  output logic             respValid,
  output logic             respHit,
  output logic [WAY_W-1:0] respWay
);
  always_comb begin
    strb.insertFire = insertValid;
    strb.lookupFire = lookupValid && !insertValid;
    strb.dataAll    = strb.lookupFire && !seqMode;
    strb.dataOne    = insertValid || (strb.lookupFire && seqMode && lookupHit);
    strb.clearStats = statClear;
  end

  // Stage 1: tag compare result. Stage 2: sequential data read.
  logic             s1Valid, s1Hit, s2Valid, s2Hit;
  logic [WAY_W-1:0] s1Way, s2Way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid <= 1'b0; s1Hit <= 1'b0; s1Way <= '0;
      s2Valid <= 1'b0; s2Hit <= 1'b0; s2Way <= '0;
    end else begin
      s1Valid <= strb.lookupFire;
      s1Hit   <= lookupHit;
      s1Way   <= lookupWay;
      s2Valid <= s1Valid;
      s2Hit   <= s1Hit;
      s2Way   <= s1Way;
    end
  end

  assign respValid = seqMode ? s2Valid : s1Valid;
  assign respHit   = seqMode ? s2Hit   : s1Hit;
  assign respWay   = seqMode ? s2Way   : s1Way;

  assert_par_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lookupFire && !seqMode) |=> (respValid || seqMode));
  assert_dropped_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lookupValid || insertValid) && !seqMode |=> (!respValid || seqMode));
endmodule

// File: rtl/tag_lookup_unit.sv
module tag_lookup_unit
  import tlu_pkg::*;
#(
  parameter int CACHE_BYTES = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 32,
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seqMode,
  input  logic              statClear,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              insertValid,
  input  logic [ADDR_W-1:0] insertAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [WAY_W-1:0]  respWay,
  output logic [WAY_W-1:0]  insertWay,
  output logic [CNT_W-1:0]  tagAccessCount,
  output logic [CNT_W-1:0]  dataAccessCount
);
  // R1: geometry legality
  if (BLOCK_BYTES < 4 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
    $fatal(1, "block size must be a power of two of at least 4");
  end
  if (WAYS < 2 || SETS < 2 || TAG_W < 1) begin : g_bad_geom
    $fatal(1, "geometry needs at least two ways, two sets and one tag bit");
  end

  tlu_strobe_t      strb;
  logic             lookupHit;
  logic [WAY_W-1:0] lookupWay;

  tlu_ctrl #(.WAY_W(WAY_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .seqMode(seqMode), .statClear(statClear),
    .lookupValid(lookupValid), .insertValid(insertValid),
    .lookupHit(lookupHit), .lookupWay(lookupWay), .strb(strb),
    .respValid(respValid), .respHit(respHit), .respWay(respWay)
  );

  tlu_datapath #(
    .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .lookupAddr(lookupAddr), .insertAddr(insertAddr),
    .lookupHit(lookupHit), .lookupWay(lookupWay), .insertWay(insertWay),
    .tagCount(tagAccessCount), .dataCount(dataAccessCount)
  );
endmodule

// File: tb/tag_lookup_unit_tb_top.sv
`timescale 1ns/1ps
module tag_lookup_unit_tb_top;
  localparam int NW = 4, NS = 4, CW = 10, CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, seqMode = 0, statClear = 0;
  logic lookupValid = 0, insertValid = 0;
  logic [15:0] lookupAddr = '0, insertAddr = '0;
  logic respValid, respHit;
  logic [1:0] respWay, insertWay;
  logic [CW-1:0] tagAccessCount, dataAccessCount;

  always #4 clk = ~clk;  // 125 MHz

  tag_lookup_unit #(.CACHE_BYTES(256), .BLOCK_BYTES(16), .WAYS(NW),
                    .ADDR_W(16), .CNT_W(CW)) dut_i (.*);

  int checks = 0, failures = 0;
  int tagExp = 0, dataExp = 0;
  int mTag [NS][NW];
  bit mValid [NS][NW];
  int mAge [NS][NW];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic logic [15:0] mkAddr(int tag, int idx, int off);
    return {tag[9:0], idx[1:0], off[3:0]};
  endfunction

  function automatic void touch(int s, int w);
    for (int k = 0; k < NW; k++)
      if (k != w && mAge[s][k] < mAge[s][w]) mAge[s][k]++;
    mAge[s][w] = 0;
  endfunction

  function automatic int victim(int s);
    for (int k = 0; k < NW; k++) if (!mValid[s][k]) return k;
    for (int k = 0; k < NW; k++) if (mAge[s][k] == NW - 1) return k;
    return -1;
  endfunction

  task automatic checkCounts(string req);
    check({req, " tag count"}, int'(tagAccessCount), tagExp);
    check({req, " data count"}, int'(dataAccessCount), dataExp);
  endtask

  task automatic doLookup(int tag, int idx, int off, string req);
    int hw = -1;
    for (int k = 0; k < NW; k++)
      if (mValid[idx][k] && mTag[idx][k] == tag) hw = k;
    @(negedge clk);
    lookupValid = 1; lookupAddr = mkAddr(tag, idx, off);
    @(negedge clk);
    lookupValid = 0;
    tagExp = sat(tagExp + NW);
    dataExp = sat(dataExp + (seqMode ? (hw >= 0 ? 1 : 0) : NW));
    if (hw >= 0) touch(idx, hw);
    checkCounts(seqMode ? {req, " R4 R6"} : {req, " R4 R5"});
    if (seqMode) begin
      check({req, " R3 seq not early"}, int'(respValid), 0);
      @(negedge clk);
    end
    check({req, " R3 respValid"}, int'(respValid), 1);
    check({req, " R2 hit"}, int'(respHit), hw >= 0);
    if (hw >= 0) check({req, " R2 way"}, int'(respWay), hw);
    @(negedge clk);
    check({req, " R3 single pulse"}, int'(respValid), 0);
  endtask

  task automatic doInsert(int tag, int idx, bit withLookup);
    int v = victim(idx);
    @(negedge clk);
    insertValid = 1; insertAddr = mkAddr(tag, idx, 0);
    lookupValid = withLookup; lookupAddr = mkAddr(tag, idx, 0);
    @(negedge clk);
    insertValid = 0; lookupValid = 0;
    mValid[idx][v] = 1; mTag[idx][v] = tag; touch(idx, v);
    tagExp = sat(tagExp + 1); dataExp = sat(dataExp + 1);
    check("R7 victim way", int'(insertWay), v);
    checkCounts(withLookup ? "R9 R7" : "R7");
    if (withLookup) begin
      check("R9 no response", int'(respValid), 0);
      @(negedge clk);
      check("R9 no late response", int'(respValid), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mValid[s][w] = 0; mTag[s][w] = 0; mAge[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    check("R12 respValid", int'(respValid), 0);
    checkCounts("R12");
    doLookup(5, 1, 0, "R12 empty miss");

    // R1 R7: fill every set; victims follow invalid-first order
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) doInsert(s * 16 + w + 1, s, 0);
    // R1 R2: every block hits from any offset, and tags from other sets miss
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        doLookup(s * 16 + w + 1, s, (w * 5 + s) % 16, "R1 R2 hit sweep");
        doLookup(((s + 1) % NS) * 16 + w + 1, s, 3, "R1 R2 miss sweep");
      end
    // R8: reorder set 2 by hits, then replacement follows LRU
    doLookup(2 * 16 + 3, 2, 0, "R8 touch");
    doLookup(2 * 16 + 1, 2, 0, "R8 touch");
    for (int k = 0; k < 6; k++) begin
      doInsert(200 + k, 2, 0);
      doLookup(2 * 16 + 3, 2, 0, "R8 keep MRU");
    end

    // Sequential mode, with the pipeline drained first
    @(negedge clk); seqMode = 1;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        if (mValid[s][w]) doLookup(mTag[s][w], s, w, "R6 seq hit");
        doLookup(900 + w, s, 0, "R6 seq miss");
      end
    doInsert(300, 0, 1);   // R9 in sequential mode
    @(negedge clk); seqMode = 0;
    doInsert(301, 1, 1);   // R9 in parallel mode
    doLookup(300, 0, 0, "R9 insert kept");

    // R11: a clear wins over a lookup in the same cycle
    @(negedge clk);
    statClear = 1; lookupValid = 1; lookupAddr = mkAddr(300, 0, 0);
    @(negedge clk);
    statClear = 0; lookupValid = 0;
    tagExp = 0; dataExp = 0;
    checkCounts("R11 clear");
    check("R11 lookup still answered", int'(respValid), 1);

    // R10: saturation of both counters
    for (int k = 0; k < 260; k++) doLookup(777, 3, 0, "R10 saturate");
    check("R10 tag max", int'(tagAccessCount), CMAX);
    check("R10 data max", int'(dataAccessCount), CMAX);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule